// File: doc/BRIEF.md
# Multi-Rate PCS Line-Mode Configuration Sequencer

This block brings a multi-rate serial Ethernet PCS into one of three line modes: USXGMII, 10GBase-R or 5GBase-R. A start pulse together with a two-bit mode code launches a fixed hardware sequence. The sequence first pulses the PCS reset and waits for it to settle. It then programs the autonegotiation control word and the link timers. After that it gates the MAC clock, forces the interface, writes the rate-adapt and speed fields, and ungates the clock. Last, it releases interface force, but only when autonegotiation is enabled. Every wait is counted in clock cycles and set by a parameter.

The three configuration words are plain output ports with a fixed bit layout, so downstream PCS logic can decode them directly. The block reports completion with a one-cycle done pulse. It rejects an unsupported code with a one-cycle error pulse. It also tells whether the requested mode differs from the mode it has stored. A disable input clears the stored mode to "none", so the next configuration always reports a change.

Top module: `pcs_mode_seq`

## Requirements
- R1: The mode code is read as 0 = USXGMII, 1 = 10GBase-R, 2 = 5GBase-R and 3 = unsupported. Only USXGMII enables autonegotiation.
- R2: After a configuration, the AN control word holds the sync count at bits 30:11 and the AN enable at bit 0. The sync count is 0x1FF for USXGMII and 10GBase-R and 0xFF for 5GBase-R. All other bits are 0.
- R3: After a configuration, the link-timer word holds three 10-bit timers at bits 29:20, 19:10 and 9:0. All three are 0x07B in the 10G modes and 0x03D in 5GBase-R. Bits 31:30 are 0.
- R4: After a configuration, the speed word has bit 31 (rate update) set only for 10GBase-R and 5GBase-R. Its rate-adapt code at bits 10:8 is 0. Its RX speed at bits 6:4 and TX speed at bits 2:0 are both 0 for the 10G modes and 1 for 5GBase-R.
- R5: The reset output is high for exactly RST_CYC cycles, starting in the cycle after an accepted start. No configuration word changes until SETTLE_CYC further cycles have elapsed.
- R6: The MAC clock gate (speed word bit 29) is high for exactly GATE_CYC+3 cycles. The speed fields at bits 6:0 change only while the gate is high.
- R7: When done is pulsed, the clock gate is 0. Interface force (speed word bit 28) is then 0 if autonegotiation is enabled and 1 otherwise.
- R8: Done is a single-cycle pulse. It appears RST_CYC+SETTLE_CYC+GATE_CYC+UNGATE_CYC+4 clock edges after the edge that accepted the start.
- R9: A start with code 3 gives a one-cycle error pulse in the next cycle. It gives no done and no reset pulse, and it leaves every configuration word and the stored mode unchanged.
- R10: On an accepted start, the mode-changed output is set if the requested mode differs from the stored mode and cleared otherwise. It holds until the next accepted start, and the stored mode takes the requested value.
- R11: A disable pulse sets the stored mode to "none". A start presented in the same cycle as disable is ignored: no reset pulse and no error.
- R12: A start that arrives while a sequence is running is ignored. The running sequence keeps its timing and gives exactly one done, and no error is raised.
- R13: After reset, all configuration words, the reset output, done, error and mode-changed are 0, and the stored mode is "none".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| mode_i | input | 2 | Requested line mode code |
| disable_i | input | 1 | Clears the stored mode to none |
| pcs_rst_o | output | 1 | Reset to the PCS, active high |
| an_ctrl_o | output | 32 | Autonegotiation control word |
| link_tmr_o | output | 32 | Packed link-timer word |
| speed_ctrl_o | output | 32 | Speed control word (rate update, gate, force, adapt, speeds) |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle unsupported-mode pulse |
| mode_chg_o | output | 1 | Requested mode differed from stored mode |

## Verification
The assertions check several things on every cycle. They check that the speed fields move only under a closed clock gate, and that the AN word holds still while the PCS reset is asserted. They check that done and error never coincide, that done lasts one cycle, and that force and gate have their final values at done. They also check that an error pulse leaves every word untouched. Other behaviour can only be shown by the bench scenarios, which run whole configurations. These include the exact reset, gate and done latencies, and the per-mode field values. They also include the mode-changed history across repeated, rejected and disabled configurations, and the immunity to starts injected mid-sequence.

// File: rtl/pcs_mode_seq_pkg.sv
package pcs_mode_seq_pkg;

   typedef enum logic [1:0] {
      LM_USX  = 2'd0,
      LM_10GR = 2'd1,
      LM_5GR  = 2'd2,
      LM_NONE = 2'd3
   } line_mode_e;

   typedef struct packed {
      logic        valid;
      logic        an_en;
      logic        rate_upd;
      logic [19:0] sync_cnt;
      logic [9:0]  tmr;
      logic [2:0]  spd;
   } mode_cfg_t;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RESET,
      ST_SETTLE,
      ST_GATE,
      ST_FORCE,
      ST_ADAPT,
      ST_SPEED,
      ST_HOLD_GATED,
      ST_HOLD_OPEN
   } seq_state_e;

   localparam int unsigned SPD_10G = 0;
   localparam int unsigned SPD_5G  = 1;

endpackage

// File: rtl/pcs_mode_table.sv
module pcs_mode_table
   import pcs_mode_seq_pkg::*;
#(
   parameter int unsigned SYNC_10G = 32'h1FF,
   parameter int unsigned SYNC_5G  = 32'h0FF,
   parameter int unsigned TMR_10G  = 32'h07B,
   parameter int unsigned TMR_5G   = 32'h03D
) (
   input  logic [1:0] mode_i,
   output mode_cfg_t  cfg_o
);

   generate
      if (SYNC_10G >= (1 << 20) || SYNC_5G >= (1 << 20)) begin : g_sync_chk
         $error("sync count does not fit its 20-bit field");
      end
      if (TMR_10G >= (1 << 10) || TMR_5G >= (1 << 10)) begin : g_tmr_chk
         $error("link timer does not fit its 10-bit field");
      end
   endgenerate

   always_comb begin
      cfg_o = '0;
      case (line_mode_e'(mode_i))
         LM_USX: begin
            cfg_o.valid    = 1'b1;
            cfg_o.an_en    = 1'b1;
            cfg_o.rate_upd = 1'b0;
            cfg_o.sync_cnt = 20'(SYNC_10G);
            cfg_o.tmr      = 10'(TMR_10G);
            cfg_o.spd      = 3'(SPD_10G);
         end
         LM_10GR: begin
            cfg_o.valid    = 1'b1;
            cfg_o.an_en    = 1'b0;
            cfg_o.rate_upd = 1'b1;
            cfg_o.sync_cnt = 20'(SYNC_10G);
            cfg_o.tmr      = 10'(TMR_10G);
            cfg_o.spd      = 3'(SPD_10G);
         end
         LM_5GR: begin
            cfg_o.valid    = 1'b1;
            cfg_o.an_en    = 1'b0;
            cfg_o.rate_upd = 1'b1;
            cfg_o.sync_cnt = 20'(SYNC_5G);
            cfg_o.tmr      = 10'(TMR_5G);
            cfg_o.spd      = 3'(SPD_5G);
         end
         default: cfg_o = '0;
      endcase
   end

endmodule

// File: rtl/pcs_wait_cnt.sv
module pcs_wait_cnt #(
   parameter int unsigned CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             zero_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pcs_mode_track.sv
module pcs_mode_track
   import pcs_mode_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       accept_i,
   input  logic       clear_i,
   input  logic [1:0] mode_i,
   output logic       chg_o
);

   line_mode_e stored_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stored_q <= LM_NONE;
         chg_o    <= 1'b0;
      end else begin
         if (clear_i) begin
            stored_q <= LM_NONE;
         end else if (accept_i) begin
            stored_q <= line_mode_e'(mode_i);
         end
         if (accept_i) begin
            chg_o <= (line_mode_e'(mode_i) != stored_q);
         end
      end
   end

endmodule

// File: rtl/pcs_mode_seq.sv
module pcs_mode_seq
   import pcs_mode_seq_pkg::*;
#(
   parameter int unsigned RST_CYC    = 10000,
   parameter int unsigned SETTLE_CYC = 1000000,
   parameter int unsigned GATE_CYC   = 100,
   parameter int unsigned UNGATE_CYC = 100,
   parameter int unsigned SYNC_10G   = 32'h1FF,
   parameter int unsigned SYNC_5G    = 32'h0FF,
   parameter int unsigned TMR_10G    = 32'h07B,
   parameter int unsigned TMR_5G     = 32'h03D
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic [1:0]  mode_i,
   input  logic        disable_i,
   output logic        pcs_rst_o,
   output logic [31:0] an_ctrl_o,
   output logic [31:0] link_tmr_o,
   output logic [31:0] speed_ctrl_o,
   output logic        done_o,
   output logic        err_o,
   output logic        mode_chg_o
);

   localparam int unsigned MAX_A = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
   localparam int unsigned MAX_B = (GATE_CYC > UNGATE_CYC) ? GATE_CYC : UNGATE_CYC;
   localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int unsigned CNT_W = (MAX_C < 2) ? 1 : $clog2(MAX_C);
   localparam logic [CNT_W-1:0] LD_RST    = CNT_W'(RST_CYC - 1);
   localparam logic [CNT_W-1:0] LD_SETTLE = CNT_W'(SETTLE_CYC - 1);
   localparam logic [CNT_W-1:0] LD_GATE   = CNT_W'(GATE_CYC - 1);
   localparam logic [CNT_W-1:0] LD_UNGATE = CNT_W'(UNGATE_CYC - 1);

   localparam int unsigned B_UPD   = 31;
   localparam int unsigned B_GATE  = 29;
   localparam int unsigned B_FORCE = 28;

   generate
      if (RST_CYC < 1 || SETTLE_CYC < 1 || GATE_CYC < 1 || UNGATE_CYC < 1) begin : g_wait_chk
         $error("every wait interval must be at least one cycle");
      end
   endgenerate

   seq_state_e       state_q;
   mode_cfg_t        req_cfg;
   mode_cfg_t        cfg_q;
   logic             accept;
   logic             t_load;
   logic [CNT_W-1:0] t_val;
   logic             t_zero;

   pcs_mode_table #(
      .SYNC_10G(SYNC_10G), .SYNC_5G(SYNC_5G),
      .TMR_10G (TMR_10G),  .TMR_5G (TMR_5G)
   ) u_table (
      .mode_i(mode_i),
      .cfg_o (req_cfg)
   );

   assign accept = (state_q == ST_IDLE) && start_i && !disable_i && req_cfg.valid;

   pcs_mode_track u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept_i(accept),
      .clear_i (disable_i),
      .mode_i  (mode_i),
      .chg_o   (mode_chg_o)
   );

   always_comb begin
      t_load = 1'b0;
      t_val  = LD_RST;
      case (state_q)
         ST_IDLE:       begin t_load = accept;  t_val = LD_RST;    end
         ST_RESET:      begin t_load = t_zero;  t_val = LD_SETTLE; end
         ST_SPEED:      begin t_load = 1'b1;    t_val = LD_GATE;   end
         ST_HOLD_GATED: begin t_load = t_zero;  t_val = LD_UNGATE; end
         default:       begin t_load = 1'b0;    t_val = LD_RST;    end
      endcase
   end

   pcs_wait_cnt #(.CNT_W(CNT_W)) u_wait (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (t_load),
      .load_val_i(t_val),
      .zero_o    (t_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         cfg_q        <= '0;
         pcs_rst_o    <= 1'b0;
         an_ctrl_o    <= '0;
         link_tmr_o   <= '0;
         speed_ctrl_o <= '0;
         done_o       <= 1'b0;
         err_o        <= 1'b0;
      end else begin
         done_o <= 1'b0;
         err_o  <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  cfg_q     <= req_cfg;
                  pcs_rst_o <= 1'b1;
                  state_q   <= ST_RESET;
               end else if (start_i && !disable_i) begin
                  err_o <= 1'b1;
               end
            end
            ST_RESET: begin
               if (t_zero) begin
                  pcs_rst_o <= 1'b0;
                  state_q   <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               if (t_zero) begin
                  an_ctrl_o  <= {1'b0, cfg_q.sync_cnt, 10'b0, cfg_q.an_en};
                  link_tmr_o <= {2'b0, cfg_q.tmr, cfg_q.tmr, cfg_q.tmr};
                  state_q    <= ST_GATE;
               end
            end
            ST_GATE: begin
               speed_ctrl_o[B_GATE] <= 1'b1;
               state_q              <= ST_FORCE;
            end
            ST_FORCE: begin
               speed_ctrl_o[B_FORCE] <= 1'b1;
               state_q               <= ST_ADAPT;
            end
            ST_ADAPT: begin
               speed_ctrl_o[B_UPD]  <= cfg_q.rate_upd;
               speed_ctrl_o[10:8]   <= 3'd0;
               state_q              <= ST_SPEED;
            end
            ST_SPEED: begin
               speed_ctrl_o[6:4] <= cfg_q.spd;
               speed_ctrl_o[2:0] <= cfg_q.spd;
               state_q           <= ST_HOLD_GATED;
            end
            ST_HOLD_GATED: begin
               if (t_zero) begin
                  speed_ctrl_o[B_GATE] <= 1'b0;
                  state_q              <= ST_HOLD_OPEN;
               end
            end
            ST_HOLD_OPEN: begin
               if (t_zero) begin
                  if (cfg_q.an_en) begin
                     speed_ctrl_o[B_FORCE] <= 1'b0;
                  end
                  done_o  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R6
   spd_under_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(speed_ctrl_o[6:0]) |-> speed_ctrl_o[B_GATE]);

   // R5
   an_quiet_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pcs_rst_o |=> $stable(an_ctrl_o));

   // R9
   done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7
   force_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (speed_ctrl_o[B_FORCE] == !an_ctrl_o[0]) && !speed_ctrl_o[B_GATE]);

   // R9
   err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $stable(an_ctrl_o) && $stable(link_tmr_o) && $stable(speed_ctrl_o) && !pcs_rst_o);

endmodule

// File: tb/pcs_mode_seq_test.sv
module pcs_mode_seq_test;

   localparam int NR = 5;
   localparam int NS = 20;
   localparam int NG = 3;
   localparam int NU = 4;
   localparam int T  = NR + NS + NG + NU + 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start_i;
   logic [1:0]  mode_i;
   logic        disable_i;
   logic        pcs_rst_o;
   logic [31:0] an_ctrl_o;
   logic [31:0] link_tmr_o;
   logic [31:0] speed_ctrl_o;
   logic        done_o;
   logic        err_o;
   logic        mode_chg_o;

   int n_chk = 0;
   int n_bad = 0;
   int model_st = 3;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   pcs_mode_seq #(
      .RST_CYC(NR), .SETTLE_CYC(NS), .GATE_CYC(NG), .UNGATE_CYC(NU)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .disable_i(disable_i), .pcs_rst_o(pcs_rst_o), .an_ctrl_o(an_ctrl_o),
      .link_tmr_o(link_tmr_o), .speed_ctrl_o(speed_ctrl_o), .done_o(done_o),
      .err_o(err_o), .mode_chg_o(mode_chg_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_an(input int m);
      logic [19:0] s;
      s = (m == 2) ? 20'h0FF : 20'h1FF;
      return {1'b0, s, 10'b0, (m == 0)};
   endfunction

   function automatic logic [31:0] exp_tmr(input int m);
      logic [9:0] t;
      t = (m == 2) ? 10'h03D : 10'h07B;
      return {2'b0, t, t, t};
   endfunction

   function automatic logic [31:0] exp_spd(input int m);
      logic [2:0] s;
      logic [31:0] w;
      s = (m == 2) ? 3'd1 : 3'd0;
      w = '0;
      w[31] = (m != 0);
      w[28] = (m != 0);
      w[6:4] = s;
      w[2:0] = s;
      return w;
   endfunction

   task automatic run_cfg(input int m, input bit inject);
      logic [31:0] a0, l0, s0;
      logic [6:0]  prev;
      int rst_hi, gate_hi, done_at, done_cnt, bad_ord, errs, inj_k;
      bit exp_chg;
      a0 = an_ctrl_o; l0 = link_tmr_o; s0 = speed_ctrl_o;
      prev = s0[6:0];
      rst_hi = 0; gate_hi = 0; done_at = -1; done_cnt = 0; bad_ord = 0; errs = 0;
      inj_k = inject ? 2 + int'($urandom % (T - 3)) : -1;
      exp_chg = (m != model_st);
      start_i = 1'b1;
      mode_i  = 2'(m);
      for (int k = 1; k <= T + 3; k++) begin
         @(negedge clk);
         start_i = 1'b0;
         if (pcs_rst_o) rst_hi++;
         if (speed_ctrl_o[29]) gate_hi++;
         if (speed_ctrl_o[6:0] != prev && !speed_ctrl_o[29]) bad_ord++;
         prev = speed_ctrl_o[6:0];
         if (err_o) errs++;
         if (k == NR + NS) begin
            // R5: nothing written during reset and settle
            chk(an_ctrl_o == a0 && link_tmr_o == l0 && speed_ctrl_o == s0, "R5 quiet",
                an_ctrl_o ^ a0 ^ link_tmr_o ^ l0, 32'h0);
         end
         if (done_o) begin
            done_cnt++;
            if (done_at < 0) begin
               done_at = k;
               chk(an_ctrl_o == exp_an(m), "R2 an word", an_ctrl_o, exp_an(m));
               chk(link_tmr_o == exp_tmr(m), "R3 timer word", link_tmr_o, exp_tmr(m));
               chk(speed_ctrl_o == exp_spd(m), "R4/R7 speed word", speed_ctrl_o, exp_spd(m));
               chk(mode_chg_o == exp_chg, "R10 mode changed", 32'(mode_chg_o), 32'(exp_chg));
            end
         end
         if (k == inj_k) begin
            start_i = 1'b1;
            mode_i  = 2'($urandom % 4);
         end
      end
      model_st = m;
      chk(rst_hi == NR, "R5 reset length", rst_hi, NR);
      chk(gate_hi == NG + 3, "R6 gate length", gate_hi, NG + 3);
      chk(bad_ord == 0, "R6 speed under gate", bad_ord, 0);
      chk(done_at == T + 1, "R8 done latency", done_at, T + 1);
      chk(done_cnt == 1, "R12 single done", done_cnt, 1);
      chk(errs == 0, "R12 no error", errs, 0);
      // R1: mode code decoding seen through AN enable
      chk(an_ctrl_o[0] == (m == 0), "R1 an enable", 32'(an_ctrl_o[0]), 32'(m == 0));
   endtask

   task automatic run_err();
      logic [31:0] a0, l0, s0;
      a0 = an_ctrl_o; l0 = link_tmr_o; s0 = speed_ctrl_o;
      start_i = 1'b1;
      mode_i  = 2'd3;
      @(negedge clk);
      start_i = 1'b0;
      chk(err_o == 1'b1, "R9 error pulse", 32'(err_o), 32'd1);
      chk(done_o == 1'b0 && pcs_rst_o == 1'b0, "R9 no done or reset",
          32'({done_o, pcs_rst_o}), 32'd0);
      chk(an_ctrl_o == a0 && link_tmr_o == l0 && speed_ctrl_o == s0, "R9 words kept",
          speed_ctrl_o, s0);
      @(negedge clk);
      chk(err_o == 1'b0 && pcs_rst_o == 1'b0, "R9 single error pulse", 32'({err_o, pcs_rst_o}), 32'd0);
   endtask

   task automatic run_dis(input bit with_start);
      int bad;
      bad = 0;
      disable_i = 1'b1;
      if (with_start) begin
         start_i = 1'b1;
         mode_i  = 2'($urandom % 3);
      end
      @(negedge clk);
      disable_i = 1'b0;
      start_i   = 1'b0;
      model_st  = 3;
      for (int k = 0; k < 3; k++) begin
         if (pcs_rst_o || err_o || done_o) bad++;
         @(negedge clk);
      end
      chk(bad == 0, "R11 start with disable ignored", bad, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      rst_n = 1'b0; start_i = 1'b0; mode_i = 2'd0; disable_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13: reset state
      chk(an_ctrl_o == 0 && link_tmr_o == 0 && speed_ctrl_o == 0, "R13 words zero",
          an_ctrl_o | link_tmr_o | speed_ctrl_o, 32'h0);
      chk({pcs_rst_o, done_o, err_o, mode_chg_o} == 4'b0, "R13 flags zero",
          32'({pcs_rst_o, done_o, err_o, mode_chg_o}), 32'h0);

      run_cfg(0, 1'b0);   // R13: first config reports change from none
      run_cfg(0, 1'b1);
      run_cfg(1, 1'b0);
      run_cfg(2, 1'b1);
      run_err();
      run_cfg(2, 1'b0);   // R9: stored mode survived the rejected start
      run_dis(1'b0);
      run_cfg(2, 1'b0);   // R11: change reported after disable
      run_dis(1'b1);
      run_cfg(1, 1'b1);

      for (int i = 0; i < 30; i++) begin
         int r;
         r = int'($urandom % 10);
         if (r < 7)       run_cfg(int'($urandom % 3), 1'($urandom % 2));
         else if (r == 7) run_err();
         else             run_dis(1'(r == 9));
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule